// File: doc/BRIEF.md
# Exception and Interrupt Dispatch Controller

This block works next to the program-counter logic of a single-issue processor. It watches the instruction in the execute stage. When that instruction has an unrecognised opcode, overflows in the ALU, asks for a system service, attempts a privileged operation from user mode, or is preempted by an external interrupt, the block redirects the fetch address. The new address comes from a handler vector table that is indexed by the cause. On that redirect the block records the faulting address and an encoded cause, enters kernel mode and masks interrupts.

A kernel-mode return instruction sends control back to the saved address. It also drops to user mode and unmasks interrupts. Kernel-mode write instructions fill the vector table and set the interrupt-enable and mode bits. When no event occurs, the next address is the current address plus four.

Top module: `exc_dispatch`

## Requirements
- R1: Reset (synchronous, active high) sets kernel_mode=1, irq_en=0, epc=0, cause_code=0 and cause_detail=0, and clears every vector table entry to 0.
- R2: A valid instruction with opcode_ok=0 takes an exception with cause code 1.
- R3: A valid instruction with alu_ovf=1 takes an exception with cause code 2.
- R4: A valid instruction with trap_req=1 takes an exception with cause code 3, records trap_svc in cause_detail, and enters kernel mode.
- R5: In user mode, a privileged write or a return strobe takes an exception with cause code 4, and the attempted write leaves the table, mode and enable bits unchanged.
- R6: With irq_en=1, any set irq line on a valid instruction takes an exception with cause code 0, and cause_detail holds the lowest-numbered set line.
- R7: When several causes are present on one instruction, the winner is chosen in this order: undefined (1), privilege (4), overflow (2), trap (3), interrupt (0).
- R8: On every taken exception, redirect=1, commit_ok=0, and pc_next equals vector entry [cause code]. On the next cycle epc holds instr_pc, kernel_mode=1 and irq_en=0.
- R9: Interrupt lines are level-sensitive. While irq_en=0 they are not taken. A line still held is taken on the first valid instruction after irq_en becomes 1.
- R10: A return strobe in kernel mode gives redirect=1, commit_ok=1 and pc_next=epc. Afterwards kernel_mode=0 and irq_en=1, and epc and cause are kept.
- R11: With no event, pc_next=instr_pc+4 and redirect=0. commit_ok equals instr_valid. With instr_valid=0, no state changes.
- R12: A kernel-mode privileged write (priv_sel 0 = table entry priv_idx, 1 = irq_en from priv_wdata[0], 2 = mode from priv_wdata[0] with 1 meaning kernel, 3 = no effect) takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is in the execute stage |
| instr_pc | input | XLEN | Address of that instruction |
| opcode_ok | input | 1 | Decoder recognised the opcode |
| alu_ovf | input | 1 | ALU overflow for that instruction |
| trap_req | input | 1 | Instruction is a service trap |
| trap_svc | input | SVCW | Service number of the trap |
| irq | input | NIRQ | Level-sensitive external interrupt lines |
| iret_req | input | 1 | Instruction is a return from handler |
| priv_we | input | 1 | Instruction is a privileged write |
| priv_sel | input | 2 | Target of the privileged write |
| priv_idx | input | VIDXW | Vector table index for the write |
| priv_wdata | input | XLEN | Write data |
| pc_next | output | XLEN | Next fetch address |
| redirect | output | 1 | pc_next is not the sequential address |
| commit_ok | output | 1 | Instruction result may be written back |
| epc | output | XLEN | Saved exception address |
| cause_code | output | 3 | Encoded cause of the last exception |
| cause_detail | output | DETW | Trap service number or interrupt line |
| kernel_mode | output | 1 | 1 = kernel, 0 = user |
| irq_en | output | 1 | External interrupts enabled |

## Verification
A wrong priority decision or a corrupted vector entry shows up in the same cycle: pc_next points at the wrong handler and commit_ok has the wrong value. A wrong mode, enable or saved address shows up one cycle later on kernel_mode, irq_en, epc or the cause outputs. A privileged write that should have been blocked shows up only later, when a dispatch or interrupt uses the entry or bit it would have changed. For that reason the stimulus revisits those entries after each blocked write.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_IRQ   = 3'd0,
        CAUSE_UNDEF = 3'd1,
        CAUSE_OVF   = 3'd2,
        CAUSE_TRAP  = 3'd3,
        CAUSE_PRIV  = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        PW_VEC  = 2'd0,
        PW_IE   = 2'd1,
        PW_MODE = 2'd2,
        PW_NONE = 2'd3
    } pw_sel_e;

    typedef struct packed {
        logic   take;
        cause_e code;
        logic   do_iret;
        logic   do_write;
    } decision_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
    import exc_pkg::*;
#(
    parameter int NIRQ = 4,
    parameter int SVCW = 4,
    parameter int IRQW = 2,
    parameter int DETW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic            opcode_ok,
    input  logic            alu_ovf,
    input  logic            trap_req,
    input  logic [SVCW-1:0] trap_svc,
    input  logic [NIRQ-1:0] irq,
    input  logic            iret_req,
    input  logic            priv_we,
    input  logic            kernel,
    input  logic            irq_en,
    output decision_t       dec,
    output logic [DETW-1:0] detail
);

    logic            viol;
    logic            irq_any;
    logic [IRQW-1:0] irq_idx;

    assign viol    = (priv_we | iret_req) & ~kernel;
    assign irq_any = |irq;

    always_comb begin
        irq_idx = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (irq[i]) irq_idx = IRQW'(i);
        end
    end

    always_comb begin
        dec.take     = 1'b0;
        dec.code     = CAUSE_IRQ;
        dec.do_iret  = 1'b0;
        dec.do_write = 1'b0;
        detail       = '0;
        if (instr_valid) begin
            if (!opcode_ok) begin
                dec.take = 1'b1;
                dec.code = CAUSE_UNDEF;
            end else if (viol) begin
                dec.take = 1'b1;
                dec.code = CAUSE_PRIV;
            end else if (alu_ovf) begin
                dec.take = 1'b1;
                dec.code = CAUSE_OVF;
            end else if (trap_req) begin
                dec.take = 1'b1;
                dec.code = CAUSE_TRAP;
                detail   = DETW'(trap_svc);
            end else if (irq_en && irq_any) begin
                dec.take = 1'b1;
                dec.code = CAUSE_IRQ;
                detail   = DETW'(irq_idx);
            end else if (iret_req) begin
                dec.do_iret = 1'b1;
            end else if (priv_we) begin
                dec.do_write = 1'b1;
            end
        end
    end

    // R2
    undef_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !opcode_ok) |-> (dec.take && dec.code == CAUSE_UNDEF));

    // R9
    masked_irq_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !(dec.take && dec.code == CAUSE_IRQ));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !(dec.take || dec.do_iret || dec.do_write));

    // R5
    user_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !kernel |-> !(dec.do_write || dec.do_iret));

endmodule

// File: rtl/exc_vec_table.sv
module exc_vec_table #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 8,
    parameter int IDXW  = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  logic [XLEN-1:0] wdata,
    input  logic [IDXW-1:0] ridx,
    output logic [XLEN-1:0] rdata
);

    logic [XLEN-1:0] entry [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) entry[i] <= '0;
        end else if (we && (int'(widx) < DEPTH)) begin
            entry[widx] <= wdata;
        end
    end

    assign rdata = (int'(ridx) < DEPTH) ? entry[ridx] : '0;

    // R12
    table_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && int'(widx) < DEPTH) |=> (entry[$past(widx)] == $past(wdata)));

endmodule

// File: rtl/exc_state.sv
module exc_state
    import exc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int DETW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] instr_pc,
    input  decision_t       dec,
    input  logic [DETW-1:0] detail,
    input  pw_sel_e         wsel,
    input  logic            wbit,
    output logic            kernel,
    output logic            irq_en,
    output logic [XLEN-1:0] epc,
    output cause_e          cause_code,
    output logic [DETW-1:0] cause_detail
);

    always_ff @(posedge clk) begin
        if (rst) begin
            kernel       <= 1'b1;
            irq_en       <= 1'b0;
            epc          <= '0;
            cause_code   <= CAUSE_IRQ;
            cause_detail <= '0;
        end else if (dec.take) begin
            kernel       <= 1'b1;
            irq_en       <= 1'b0;
            epc          <= instr_pc;
            cause_code   <= dec.code;
            cause_detail <= detail;
        end else if (dec.do_iret) begin
            kernel <= 1'b0;
            irq_en <= 1'b1;
        end else if (dec.do_write) begin
            if (wsel == PW_IE)   irq_en <= wbit;
            if (wsel == PW_MODE) kernel <= wbit;
        end
    end

    // R8
    entry_mask_chk: assert property (@(posedge clk) disable iff (rst)
        dec.take |=> (kernel && !irq_en && epc == $past(instr_pc)));

    // R10
    return_mode_chk: assert property (@(posedge clk) disable iff (rst)
        dec.do_iret |=> (!kernel && irq_en && $stable(epc)));

    // R11
    epc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dec.take |=> $stable(epc));

endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
    import exc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NIRQ  = 4,
    parameter int SVCW  = 4,
    parameter int VDEPTH = 8,
    localparam int VIDXW = $clog2(VDEPTH),
    localparam int IRQW  = (NIRQ > 1) ? $clog2(NIRQ) : 1,
    localparam int DETW  = max_int(SVCW, IRQW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_valid,
    input  logic [XLEN-1:0]  instr_pc,
    input  logic             opcode_ok,
    input  logic             alu_ovf,
    input  logic             trap_req,
    input  logic [SVCW-1:0]  trap_svc,
    input  logic [NIRQ-1:0]  irq,
    input  logic             iret_req,
    input  logic             priv_we,
    input  logic [1:0]       priv_sel,
    input  logic [VIDXW-1:0] priv_idx,
    input  logic [XLEN-1:0]  priv_wdata,
    output logic [XLEN-1:0]  pc_next,
    output logic             redirect,
    output logic             commit_ok,
    output logic [XLEN-1:0]  epc,
    output logic [2:0]       cause_code,
    output logic [DETW-1:0]  cause_detail,
    output logic             kernel_mode,
    output logic             irq_en
);

    decision_t       dec;
    logic [DETW-1:0] detail;
    logic [XLEN-1:0] vec_addr;
    pw_sel_e         wsel;
    cause_e          cause_q;
    logic            vec_we;

    assign wsel   = pw_sel_e'(priv_sel);
    assign vec_we = dec.do_write && (wsel == PW_VEC);

    exc_cause_sel #(
        .NIRQ(NIRQ), .SVCW(SVCW), .IRQW(IRQW), .DETW(DETW)
    ) u_sel (
        .clk(clk), .rst(rst),
        .instr_valid(instr_valid), .opcode_ok(opcode_ok), .alu_ovf(alu_ovf),
        .trap_req(trap_req), .trap_svc(trap_svc), .irq(irq),
        .iret_req(iret_req), .priv_we(priv_we),
        .kernel(kernel_mode), .irq_en(irq_en),
        .dec(dec), .detail(detail)
    );

    exc_vec_table #(
        .XLEN(XLEN), .DEPTH(VDEPTH), .IDXW(VIDXW)
    ) u_tab (
        .clk(clk), .rst(rst),
        .we(vec_we), .widx(priv_idx), .wdata(priv_wdata),
        .ridx(VIDXW'(dec.code)), .rdata(vec_addr)
    );

    exc_state #(
        .XLEN(XLEN), .DETW(DETW)
    ) u_st (
        .clk(clk), .rst(rst),
        .instr_pc(instr_pc), .dec(dec), .detail(detail),
        .wsel(wsel), .wbit(priv_wdata[0]),
        .kernel(kernel_mode), .irq_en(irq_en), .epc(epc),
        .cause_code(cause_q), .cause_detail(cause_detail)
    );

    assign cause_code = cause_q;

    always_comb begin
        if (dec.take)         pc_next = vec_addr;
        else if (dec.do_iret) pc_next = epc;
        else                  pc_next = instr_pc + XLEN'(4);
    end

    assign redirect  = dec.take | dec.do_iret;
    assign commit_ok = instr_valid & ~dec.take;

    // R8
    take_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !opcode_ok) |-> (redirect && !commit_ok));

    // R5
    user_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && !kernel_mode && priv_we) |=> (kernel_mode && cause_code == 3'd4)
            || $past(!opcode_ok));

    // R4
    trap_kernel_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && opcode_ok && trap_req && !alu_ovf && !priv_we && !iret_req)
            |=> (kernel_mode && cause_code == 3'd3));

endmodule

// File: tb/sim_exc_dispatch.sv
`timescale 1ns/1ps
module sim_exc_dispatch;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid, opcode_ok, alu_ovf, trap_req, iret_req, priv_we;
    logic [31:0] instr_pc, priv_wdata, pc_next, epc;
    logic [3:0]  trap_svc, irq, cause_detail;
    logic [1:0]  priv_sel;
    logic [2:0]  priv_idx, cause_code;
    logic        redirect, commit_ok, kernel_mode, irq_en;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    exc_dispatch u0 (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_pc(instr_pc),
        .opcode_ok(opcode_ok), .alu_ovf(alu_ovf), .trap_req(trap_req),
        .trap_svc(trap_svc), .irq(irq), .iret_req(iret_req), .priv_we(priv_we),
        .priv_sel(priv_sel), .priv_idx(priv_idx), .priv_wdata(priv_wdata),
        .pc_next(pc_next), .redirect(redirect), .commit_ok(commit_ok), .epc(epc),
        .cause_code(cause_code), .cause_detail(cause_detail),
        .kernel_mode(kernel_mode), .irq_en(irq_en)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        v;
        logic [31:0] pc;
        logic        ok, ovf, trap;
        logic [3:0]  svc, irq;
        logic        iret, we;
        logic [1:0]  sel;
        logic [2:0]  idx;
        logic [31:0] wd;
        logic        rd, cm;
        logic [31:0] npc;
        logic        k, ie;
        logic [2:0]  code;
        logic [3:0]  det;
        logic [31:0] sepc;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VT [NV] = '{
        '{1, 1,'h50,  0,0,0,0,0,      0,0,0,0,'h0,    1,0,'h0,    1,0,1,0,'h50},   // R1 cleared table
        '{12,1,'h100, 1,0,0,0,0,      0,1,0,0,'h1000, 0,1,'h104,  1,0,1,0,'h50},   // R12
        '{12,1,'h104, 1,0,0,0,0,      0,1,0,1,'h1100, 0,1,'h108,  1,0,1,0,'h50},
        '{12,1,'h108, 1,0,0,0,0,      0,1,0,2,'h1200, 0,1,'h10C,  1,0,1,0,'h50},
        '{12,1,'h10C, 1,0,0,0,0,      0,1,0,3,'h1300, 0,1,'h110,  1,0,1,0,'h50},
        '{12,1,'h110, 1,0,0,0,0,      0,1,0,4,'h1400, 0,1,'h114,  1,0,1,0,'h50},
        '{2, 1,'h114, 0,0,0,0,0,      0,0,0,0,'h0,    1,0,'h1100, 1,0,1,0,'h114},  // R2
        '{10,1,'h1104,1,0,0,0,0,      1,0,0,0,'h0,    1,1,'h114,  0,1,1,0,'h114},  // R10
        '{11,1,'h114, 1,0,0,0,0,      0,0,0,0,'h0,    0,1,'h118,  0,1,1,0,'h114},  // R11
        '{3, 1,'h118, 1,1,0,0,0,      0,0,0,0,'h0,    1,0,'h1200, 1,0,2,0,'h118},  // R3
        '{10,1,'h1204,1,0,0,0,0,      1,0,0,0,'h0,    1,1,'h118,  0,1,2,0,'h118},
        '{4, 1,'h11C, 1,0,1,5,0,      0,0,0,0,'h0,    1,0,'h1300, 1,0,3,5,'h11C},  // R4
        '{10,1,'h1300,1,0,0,0,0,      1,0,0,0,'h0,    1,1,'h11C,  0,1,3,5,'h11C},
        '{5, 1,'h120, 1,0,0,0,0,      0,1,0,0,'hDEAD, 1,0,'h1400, 1,0,4,0,'h120},  // R5 user write
        '{10,1,'h1400,1,0,0,0,0,      1,0,0,0,'h0,    1,1,'h120,  0,1,4,0,'h120},
        '{5, 1,'h124, 1,0,0,0,0,      1,0,0,0,'h0,    1,0,'h1400, 1,0,4,0,'h124},  // R5 user return
        '{10,1,'h1404,1,0,0,0,0,      1,0,0,0,'h0,    1,1,'h124,  0,1,4,0,'h124},
        '{6, 1,'h128, 1,0,0,0,'b0110, 0,0,0,0,'h0,    1,0,'h1000, 1,0,0,1,'h128},  // R6 entry 0 intact
        '{9, 1,'h1000,1,0,0,0,'b1000, 0,0,0,0,'h0,    0,1,'h1004, 1,0,0,1,'h128},  // R9 masked
        '{12,1,'h1004,1,0,0,0,'b1000, 0,1,1,0,'h1,    0,1,'h1008, 1,1,0,1,'h128},  // R12 enable
        '{9, 1,'h1008,1,0,0,0,'b1000, 0,0,0,0,'h0,    1,0,'h1000, 1,0,0,3,'h1008}, // R9 taken
        '{7, 1,'h1000,0,1,1,2,'b0001, 0,0,0,0,'h0,    1,0,'h1100, 1,0,1,0,'h1000}, // R7
        '{12,1,'h1100,1,0,0,0,0,      0,1,2,0,'h0,    0,1,'h1104, 0,0,1,0,'h1000}, // R12 mode
        '{7, 1,'h200, 1,1,1,0,'b0001, 0,1,0,1,'hBAD,  1,0,'h1400, 1,0,4,0,'h200},  // R7 priv>ovf
        '{7, 1,'h1400,1,1,1,7,0,      0,0,0,0,'h0,    1,0,'h1200, 1,0,2,0,'h1400}, // R7 ovf>trap
        '{12,1,'h1200,1,0,0,0,'b0001, 0,1,1,0,'h1,    0,1,'h1204, 1,1,2,0,'h1400},
        '{7, 1,'h1204,1,0,1,9,'b0001, 0,0,0,0,'h0,    1,0,'h1300, 1,0,3,9,'h1204}, // R7 trap>irq
        '{11,0,'h300, 0,0,0,0,'b0001, 0,0,0,0,'h0,    0,0,'h304,  1,0,3,9,'h1204}, // R11 idle
        '{12,1,'h1300,1,0,0,0,0,      0,1,3,0,'h1,    0,1,'h1304, 1,0,3,9,'h1204}, // R12 sel 3
        '{8, 1,'h1304,0,0,0,0,0,      0,0,0,0,'h0,    1,0,'h1100, 1,0,1,0,'h1304}  // R8 entry 1 intact
    };

    task automatic drive(input vec_t t);
        instr_valid = t.v;  instr_pc = t.pc;  opcode_ok = t.ok;  alu_ovf = t.ovf;
        trap_req = t.trap;  trap_svc = t.svc; irq = t.irq;       iret_req = t.iret;
        priv_we = t.we;     priv_sel = t.sel; priv_idx = t.idx;  priv_wdata = t.wd;
    endtask

    task automatic chk_out(input int req, input int n, input logic rd, input logic cm,
                           input logic [31:0] npc);
        total++;
        if (redirect !== rd || commit_ok !== cm || pc_next !== npc) begin
            bad++;
            $display("FAIL R%0d step %0d: rd/cm/pc=%b/%b/%h expected %b/%b/%h",
                     req, n, redirect, commit_ok, pc_next, rd, cm, npc);
        end
    endtask

    task automatic chk_state(input int req, input int n, input logic k, input logic ie,
                             input logic [2:0] code, input logic [3:0] det,
                             input logic [31:0] sepc);
        total++;
        if (kernel_mode !== k || irq_en !== ie || cause_code !== code ||
            cause_detail !== det || epc !== sepc) begin
            bad++;
            $display("FAIL R%0d step %0d: k/ie/code/det/epc=%b/%b/%0d/%0d/%h expected %b/%b/%0d/%0d/%h",
                     req, n, kernel_mode, irq_en, cause_code, cause_detail, epc,
                     k, ie, code, det, sepc);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        vec_t idle;
        idle = '0;
        idle.ok = 1'b1;
        drive(idle);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk_state(1, -1, 1'b1, 1'b0, 3'd0, 4'd0, 32'h0);  // R1 reset values

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VT[i]);
            #1;
            chk_out(int'(VT[i].req), i, VT[i].rd, VT[i].cm, VT[i].npc);
            @(negedge clk);
            drive(idle);
            instr_valid = 1'b0;
            #1;
            chk_state(int'(VT[i].req), i, VT[i].k, VT[i].ie, VT[i].code, VT[i].det, VT[i].sepc);
        end

        // R1 reset in mid-run clears state and table
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk_state(1, 100, 1'b1, 1'b0, 3'd0, 4'd0, 32'h0);
        @(negedge clk);
        instr_valid = 1'b1; instr_pc = 32'h400; alu_ovf = 1'b1;
        #1;
        chk_out(1, 101, 1'b1, 1'b0, 32'h0);  // R3 handler entry was cleared
        @(negedge clk);
        drive(idle);
        instr_valid = 1'b0;
        #1;
        chk_state(8, 102, 1'b1, 1'b0, 3'd2, 4'd0, 32'h400);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule